// File: doc/BRIEF.md
# Serial Converter Mode Sequencer

This block is the digital control core on the device side of a serial sampling converter. It runs entirely on the serial clock and watches the serial data input for a start bit. After the start bit it completes an eight-bit control byte. Two mode bits in that byte pick one of four actions: a short conversion frame, a long conversion frame, a calibration run, or a conversion followed by power-down. The block drives an acquire strobe, a one-cycle convert strobe, a calibration-busy flag and a power-down flag. It returns a 16-bit result, taken from an input port, on the serial output MSB-first.

A host completes a conversion with three byte transfers: the control byte goes in first, and the next two bytes carry the result back. In a long frame the host clocks an extra byte of acquisition time before the result. The analog front end, the converter core and the calibration arithmetic sit outside this block. They take their cues from the strobes and flags.

Top module: `adc_mode_seq`

## Requirements
- R1: While reset is low and after it is released, acqStrobe, convStrobe, calBusy, pwrDown and sdo are all 0, and the stored acquisition length is short.
- R2: Frame slots are numbered from 0. Slot 0 is the first clock in which sdi is 1 while the sequencer is idle, powered down or calibrating, with shdnN high. Slots 0 to 7 form the control byte. The first mode bit is the sdi value in slot 6 and the second is the sdi value in slot 7. The sdi values in slots 1 to 5 are ignored, and so is sdi in every slot after 7 until the frame ends.
- R3: Mode bits 0,0 give a short frame of 24 slots. acqStrobe is high in slots 3 to 7, which is 5 clocks. The block is idle from slot 24, and a start bit there begins a new frame.
- R4: Mode bits 1,1 give a long frame of 32 slots, with acqStrobe high in slots 3 to 15, which is 13 clocks.
- R5: convStrobe is high for exactly one clock, in the first data slot: slot 8 in a short frame and slot 16 in a long frame. resultIn is captured on the clock edge that opens that slot, so later changes to resultIn do not affect the value shifted out.
- R6: sdo carries the captured result MSB-first, one bit per slot, over the 16 slots that start at the first data slot. sdo is 0 in every other cycle.
- R7: Mode bits 0,1 start a calibration run. calBusy is high for CAL_CYCLES clocks starting at slot 8, no data is shifted out, and the stored acquisition length is left unchanged.
- R8: A start bit during a calibration run ends the run. calBusy is 0 from the next clock, and that start bit begins a normal frame.
- R9: While shdnN is low, pwrDown is 1 from the next clock and any frame or calibration run is abandoned. Start bits are ignored. acqStrobe, convStrobe, calBusy and sdo stay 0.
- R10: Mode bits 1,0 run a conversion with the stored acquisition length. The stored length is the one used by the last frame coded 0,0 or 1,1, and it is short after reset. pwrDown goes to 1 from the clock after the last slot. It stays 1, also after shdnN returns high, up to and including the next start-bit slot, and is 0 from the slot after it.
- R11: Reset during a calibration run clears calBusy and restores the stored acquisition length to short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| shdnN | input | 1 | Active-low shutdown request |
| sdi | input | 1 | Serial data in: start bit and control byte |
| resultIn | input | 16 | Conversion result to be returned |
| sdo | output | 1 | Serial data out, result MSB-first |
| acqStrobe | output | 1 | High during the acquisition window |
| convStrobe | output | 1 | One-clock pulse in the first data slot |
| calBusy | output | 1 | High while a calibration run is active |
| pwrDown | output | 1 | High while powered down |

## Verification
The bench covers the following corner cases:
- A shutdown-coded frame after both short and long frames. A design that forgot the stored length would shift the result out eight slots early or late.
- Calibration ended by a start bit, by shdnN and by reset. A design that missed any of these would hold calBusy high or lose the new frame.
- A shutdown-coded frame run right after a calibration and right after a reset. This catches a design that lets calibration overwrite the stored length or that keeps a long length across reset.
- Frames started back to back, with sdi driven high in the ignored bits and during the data slots. It also changes resultIn after capture. A design that re-sampled the result or mistook noise for a start bit would corrupt sdo.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_CAL   = 2'd2,
    ST_SLEEP = 2'd3
  } seqState_t;

  typedef struct packed {
    logic ctrlShift;   // capture the sdi bit preceding the last control bit
    logic loadResult;  // capture resultIn into the output shifter
    logic dataSlot;    // current slot drives a result bit
  } dpCtl_t;

  localparam logic [1:0] MODE_SHORT = 2'b00;
  localparam logic [1:0] MODE_CAL   = 2'b01;
  localparam logic [1:0] MODE_SLEEP = 2'b10;
  localparam logic [1:0] MODE_LONG  = 2'b11;

endpackage

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int CTRL_BITS  = 8,
  parameter int RES_BITS   = 16,
  parameter int SHORT_ACQ  = 5,
  parameter int LONG_ACQ   = 13,
  parameter int CAL_CYCLES = 80000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       shdnN,
  input  logic       sdi,
  input  logic [1:0] modeCode,
  output dpCtl_t     dpCtl,
  output logic       acqStrobe,
  output logic       convStrobe,
  output logic       calBusy,
  output logic       pwrDown
);

  localparam int ACQ_START   = CTRL_BITS - SHORT_ACQ;
  localparam int SHORT_FRAME = CTRL_BITS + RES_BITS;
  localparam int LONG_FRAME  = SHORT_FRAME + LONG_ACQ - SHORT_ACQ;
  localparam int SHORT_DATA  = CTRL_BITS;
  localparam int LONG_DATA   = CTRL_BITS + LONG_ACQ - SHORT_ACQ;
  localparam int SLOT_W      = $clog2(LONG_FRAME);
  localparam int CAL_W       = $clog2(CAL_CYCLES + 1);

  localparam logic [SLOT_W-1:0] S_ACQ_START  = SLOT_W'(ACQ_START);
  localparam logic [SLOT_W-1:0] S_DECODE     = SLOT_W'(CTRL_BITS - 1);
  localparam logic [SLOT_W-1:0] S_M1         = SLOT_W'(CTRL_BITS - 2);
  localparam logic [SLOT_W-1:0] S_SHORT_DATA = SLOT_W'(SHORT_DATA);
  localparam logic [SLOT_W-1:0] S_LONG_DATA  = SLOT_W'(LONG_DATA);
  localparam logic [SLOT_W-1:0] S_LONG_LOAD  = SLOT_W'(LONG_DATA - 1);
  localparam logic [SLOT_W-1:0] S_SHORT_LAST = SLOT_W'(SHORT_FRAME - 1);
  localparam logic [SLOT_W-1:0] S_LONG_LAST  = SLOT_W'(LONG_FRAME - 1);
  localparam logic [CAL_W-1:0]  C_LAST       = CAL_W'(CAL_CYCLES - 1);

  seqState_t         state;
  logic [SLOT_W-1:0] slot;
  logic [CAL_W-1:0]  calCnt;
  logic              curLong;
  logic              storedLong;
  logic              sleepAfter;

  logic              busy;
  logic              decodeSlot;
  logic              decLong;
  logic              startSeen;
  logic [SLOT_W-1:0] dataStart;
  logic [SLOT_W-1:0] frameLast;

  always_comb begin
    busy       = (state == ST_BUSY);
    decodeSlot = busy && (slot == S_DECODE);
    decLong    = (modeCode == MODE_LONG) || ((modeCode == MODE_SLEEP) && storedLong);
    startSeen  = sdi && shdnN && (state != ST_BUSY);
    dataStart  = curLong ? S_LONG_DATA : S_SHORT_DATA;
    frameLast  = curLong ? S_LONG_LAST : S_SHORT_LAST;

    acqStrobe  = busy && (slot >= S_ACQ_START) && (slot < dataStart);
    convStrobe = busy && (slot == dataStart);
    calBusy    = (state == ST_CAL);
    pwrDown    = (state == ST_SLEEP);

    dpCtl.ctrlShift  = busy && (slot == S_M1);
    dpCtl.dataSlot   = busy && (slot >= dataStart);
    dpCtl.loadResult = (decodeSlot && (modeCode != MODE_CAL) && !decLong)
                     || (busy && !decodeSlot && curLong && (slot == S_LONG_LOAD));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      slot       <= '0;
      calCnt     <= '0;
      curLong    <= 1'b0;
      storedLong <= 1'b0;
      sleepAfter <= 1'b0;
    end else if (!shdnN) begin
      state <= ST_SLEEP;
      slot  <= '0;
    end else if (startSeen) begin
      state <= ST_BUSY;
      slot  <= SLOT_W'(1);
    end else begin
      case (state)
        ST_BUSY: begin
          if (decodeSlot) begin
            if (modeCode == MODE_CAL) begin
              state  <= ST_CAL;
              calCnt <= '0;
              slot   <= '0;
            end else begin
              slot       <= slot + 1'b1;
              curLong    <= decLong;
              sleepAfter <= (modeCode == MODE_SLEEP);
              if (modeCode == MODE_SHORT) storedLong <= 1'b0;
              if (modeCode == MODE_LONG)  storedLong <= 1'b1;
            end
          end else if (slot == frameLast) begin
            state <= sleepAfter ? ST_SLEEP : ST_IDLE;
            slot  <= '0;
          end else begin
            slot <= slot + 1'b1;
          end
        end
        ST_CAL: begin
          if (calCnt == C_LAST) state <= ST_IDLE;
          else                  calCnt <= calCnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/adcseq_dp.sv
module adcseq_dp
  import adcseq_pkg::*;
#(
  parameter int RES_BITS = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sdi,
  input  logic [RES_BITS-1:0] resultIn,
  input  dpCtl_t              dpCtl,
  output logic [1:0]          modeCode,
  output logic                sdo
);

  logic                m1Bit;
  logic [RES_BITS-1:0] resSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      m1Bit <= 1'b0;
      resSh <= '0;
    end else begin
      if (dpCtl.ctrlShift) m1Bit <= sdi;
      if (dpCtl.loadResult)    resSh <= resultIn;
      else if (dpCtl.dataSlot) resSh <= {resSh[RES_BITS-2:0], 1'b0};
    end
  end

  assign modeCode = {m1Bit, sdi};
  assign sdo      = dpCtl.dataSlot & resSh[RES_BITS-1];

endmodule

// File: rtl/adc_mode_seq.sv
module adc_mode_seq
  import adcseq_pkg::*;
#(
  parameter int CTRL_BITS  = 8,
  parameter int RES_BITS   = 16,
  parameter int SHORT_ACQ  = 5,
  parameter int LONG_ACQ   = 13,
  parameter int CAL_CYCLES = 80000
) (
  input  logic                sclk,
  input  logic                rstN,
  input  logic                shdnN,
  input  logic                sdi,
  input  logic [RES_BITS-1:0] resultIn,
  output logic                sdo,
  output logic                acqStrobe,
  output logic                convStrobe,
  output logic                calBusy,
  output logic                pwrDown
);

  dpCtl_t     dpCtl;
  logic [1:0] modeCode;

  adcseq_ctrl #(
    .CTRL_BITS (CTRL_BITS),
    .RES_BITS  (RES_BITS),
    .SHORT_ACQ (SHORT_ACQ),
    .LONG_ACQ  (LONG_ACQ),
    .CAL_CYCLES(CAL_CYCLES)
  ) uCtrl (
    .clk       (sclk),
    .rstN      (rstN),
    .shdnN     (shdnN),
    .sdi       (sdi),
    .modeCode  (modeCode),
    .dpCtl     (dpCtl),
    .acqStrobe (acqStrobe),
    .convStrobe(convStrobe),
    .calBusy   (calBusy),
    .pwrDown   (pwrDown)
  );

  adcseq_dp #(
    .RES_BITS(RES_BITS)
  ) uDp (
    .clk     (sclk),
    .rstN    (rstN),
    .sdi     (sdi),
    .resultIn(resultIn),
    .dpCtl   (dpCtl),
    .modeCode(modeCode),
    .sdo     (sdo)
  );

endmodule

// File: rtl/adc_mode_seq_chk.sv
module adc_mode_seq_chk (
  input logic sclk,
  input logic rstN,
  input logic shdnN,
  input logic sdi,
  input logic sdo,
  input logic acqStrobe,
  input logic convStrobe,
  input logic calBusy,
  input logic pwrDown
);

  // R5: the convert strobe lasts one clock
  p_conv_pulse_r5: assert property (@(posedge sclk) disable iff (!rstN)
    convStrobe |=> !convStrobe);

  // R5: a closing acquisition window hands over to conversion, calibration or sleep
  p_acq_close_r5: assert property (@(posedge sclk) disable iff (!rstN)
    $fell(acqStrobe) |-> (convStrobe || calBusy || pwrDown));

  // R6: no result bit during acquisition
  p_acq_quiet_r6: assert property (@(posedge sclk) disable iff (!rstN)
    acqStrobe |-> !sdo);

  // R7: calibration produces no acquisition or data
  p_cal_quiet_r7: assert property (@(posedge sclk) disable iff (!rstN)
    calBusy |-> (!sdo && !acqStrobe && !convStrobe));

  // R7: calibration begins right after the control byte
  p_cal_entry_r7: assert property (@(posedge sclk) disable iff (!rstN)
    $rose(calBusy) |-> $past(acqStrobe));

  // R9: shutdown input forces power-down on the next clock
  p_shdn_sleep_r9: assert property (@(posedge sclk) disable iff (!rstN)
    !shdnN |=> pwrDown);

  // R9: power-down keeps every other output low
  p_sleep_quiet_r9: assert property (@(posedge sclk) disable iff (!rstN)
    pwrDown |-> (!acqStrobe && !convStrobe && !calBusy && !sdo));

  // R10: waking needs a start bit with shutdown released
  p_wake_start_r10: assert property (@(posedge sclk) disable iff (!rstN)
    ($fell(pwrDown) && $past(rstN)) |-> ($past(sdi) && $past(shdnN)));

endmodule

bind adc_mode_seq adc_mode_seq_chk uChk (
  .sclk      (sclk),
  .rstN      (rstN),
  .shdnN     (shdnN),
  .sdi       (sdi),
  .sdo       (sdo),
  .acqStrobe (acqStrobe),
  .convStrobe(convStrobe),
  .calBusy   (calBusy),
  .pwrDown   (pwrDown)
);

// File: tb/sim_adc_mode_seq.sv
module sim_adc_mode_seq;

  localparam int CAL_N = 40;

  logic        sclk = 1'b0;
  logic        rstN = 1'b0;
  logic        shdnN = 1'b1;
  logic        sdi = 1'b0;
  logic [15:0] resultIn = '0;
  logic        sdo, acqStrobe, convStrobe, calBusy, pwrDown;

  int nChecks = 0;
  int nBad = 0;
  bit finished = 1'b0;

  adc_mode_seq #(.CAL_CYCLES(CAL_N)) u0 (
    .sclk(sclk), .rstN(rstN), .shdnN(shdnN), .sdi(sdi), .resultIn(resultIn),
    .sdo(sdo), .acqStrobe(acqStrobe), .convStrobe(convStrobe),
    .calBusy(calBusy), .pwrDown(pwrDown)
  );

  always #4 sclk = ~sclk;

  // vector: code[20:19] result[18:3] long[2] sleep[1] noise[0]
  localparam int NV = 7;
  localparam logic [20:0] VEC [NV] = '{
    {2'b00, 16'hA5C3, 1'b0, 1'b0, 1'b0},
    {2'b11, 16'h8001, 1'b1, 1'b0, 1'b1},
    {2'b10, 16'h1234, 1'b1, 1'b1, 1'b0},
    {2'b00, 16'hFFFE, 1'b0, 1'b0, 1'b1},
    {2'b10, 16'h0F0F, 1'b0, 1'b1, 1'b0},
    {2'b11, 16'h7FFF, 1'b1, 1'b0, 1'b0},
    {2'b00, 16'h0001, 1'b0, 1'b0, 1'b1}
  };

  function automatic logic [4:0] obs();
    return {acqStrobe, convStrobe, calBusy, pwrDown, sdo};
  endfunction

  task automatic check(input string req, input logic [4:0] exp);
    nChecks++;
    if (obs() !== exp) begin
      nBad++;
      $display("FAIL %s got acq,conv,cal,pd,sdo=%b expected=%b at %0t", req, obs(), exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge sclk);
    #2;
  endtask

  // drives one conversion frame from its start-bit slot; outputs checked per slot
  task automatic runFrame(input logic [1:0] code, input logic [15:0] res, input bit isLong,
                          input bit noise, input bit prevPd, input bit prevCal, input string req);
    int ds = isLong ? 16 : 8;
    int len = isLong ? 32 : 24;
    resultIn = res;
    for (int s = 0; s < len; s++) begin
      logic [4:0] e;
      if (s == 0)      sdi = 1'b1;
      else if (s == 6) sdi = code[1];
      else if (s == 7) sdi = code[0];
      else             sdi = noise;
      if (s == ds) resultIn = ~res;  // R5: late change must not reach sdo
      e[4] = (s >= 3) && (s < ds);
      e[3] = (s == ds);
      e[2] = (s == 0) ? prevCal : 1'b0;
      e[1] = (s == 0) ? prevPd : 1'b0;
      e[0] = (s >= ds) ? res[15 - (s - ds)] : 1'b0;
      check(req, e);
      tick();
    end
    sdi = 1'b0;
  endtask

  // drives a calibration control byte; leaves the bench in the first calibration cycle
  task automatic calStart(input bit prevPd, input bit prevCal);
    for (int s = 0; s < 8; s++) begin
      logic [4:0] e;
      sdi = (s == 0) || (s == 7);
      e = {(s >= 3), 1'b0, (s == 0) ? prevCal : 1'b0, (s == 0) ? prevPd : 1'b0, 1'b0};
      check("R7 cal byte", e);
      tick();
    end
    sdi = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nBad++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    bit pd;
    #2;
    tick();
    check("R1 in reset", 5'b00000);
    tick();
    rstN = 1'b1;
    tick();
    check("R1 after reset", 5'b00000);

    // table walk: R2 R3 R4 R5 R6 R10
    pd = 1'b0;
    for (int i = 0; i < NV; i++) begin
      logic [20:0] v = VEC[i];
      runFrame(v[20:19], v[18:3], v[2], v[0], pd, 1'b0, "R3/R4/R6 table frame");
      pd = v[1];
      for (int g = 0; g < 2; g++) begin
        check("R10 post-frame", {3'b000, pd, 1'b0});
        tick();
      end
    end

    // R3: back-to-back frames, start accepted right at slot 24
    runFrame(2'b00, 16'h5A5A, 1'b0, 1'b0, 1'b0, 1'b0, "R3 back-to-back first");
    runFrame(2'b11, 16'hC003, 1'b1, 1'b1, 1'b0, 1'b0, "R4 back-to-back second");
    check("R4 idle after long", 5'b00000);

    // R7: full calibration keeps the stored long length
    calStart(1'b0, 1'b0);
    for (int c = 0; c < CAL_N; c++) begin
      check("R7 cal busy", 5'b00100);
      tick();
    end
    check("R7 cal done", 5'b00000);
    tick();
    runFrame(2'b10, 16'h3C3C, 1'b1, 1'b0, 1'b0, 1'b0, "R7 length kept / R10 sleep frame");
    check("R10 sleep after frame", 5'b00010);
    tick();
    runFrame(2'b00, 16'h9999, 1'b0, 1'b0, 1'b1, 1'b0, "R10 wake frame");

    // R8: start bit aborts calibration and begins a frame
    calStart(1'b0, 1'b0);
    for (int c = 0; c < 10; c++) begin
      check("R8 cal running", 5'b00100);
      tick();
    end
    runFrame(2'b00, 16'h6E21, 1'b0, 1'b0, 1'b0, 1'b1, "R8 abort by start");
    check("R8 idle after frame", 5'b00000);

    // R9: shutdown input aborts calibration and blocks starts
    calStart(1'b0, 1'b0);
    tick();
    check("R9 cal before shdn", 5'b00100);
    shdnN = 1'b0;
    tick();
    check("R9 shdn forces sleep", 5'b00010);
    sdi = 1'b1;
    for (int c = 0; c < 6; c++) begin
      tick();
      check("R9 starts ignored", 5'b00010);
    end
    sdi = 1'b0;
    shdnN = 1'b1;
    tick();
    check("R10 stays asleep", 5'b00010);
    runFrame(2'b11, 16'hB00B, 1'b1, 1'b0, 1'b1, 1'b0, "R9 wake after shdn");

    // R9: shutdown in the middle of a data phase
    resultIn = 16'hFFFF;
    sdi = 1'b1; tick();
    sdi = 1'b0;
    for (int s = 1; s < 12; s++) tick();
    shdnN = 1'b0;
    tick();
    check("R9 shdn mid-frame", 5'b00010);
    shdnN = 1'b1;
    tick();
    check("R9 frame abandoned", 5'b00010);
    runFrame(2'b11, 16'h0FF0, 1'b1, 1'b0, 1'b1, 1'b0, "R9 set long");

    // R11: reset during calibration restores short length
    calStart(1'b0, 1'b0);
    tick();
    rstN = 1'b0;
    tick();
    check("R11 reset clears cal", 5'b00000);
    rstN = 1'b1;
    tick();
    check("R11 after reset", 5'b00000);
    runFrame(2'b10, 16'h4321, 1'b0, 1'b0, 1'b0, 1'b0, "R11 short after reset");
    check("R10 sleep after short", 5'b00010);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule